// File: doc/BRIEF.md
# ADC Output Test-Pattern Generator

This block sits between a converter core and its output serializer. On each sample strobe it registers one output word: either the live converter sample or a deterministic test word. A 4-bit mode code selects the pattern, and a 2-bit code sets the word length. A receiver that knows the selected pattern can then check its capture path bit by bit, with no dependence on the analog input.

The catalogue has thirteen codes. There are constant words such as midscale, full scale, a sync word and a mixed-frequency word. There are alternating pairs: checkerboard, word toggle, and two user-programmed words. There are two pseudo-random sequences. Alternating patterns restart on their first word whenever the mode differs from the mode of the previous sample. The pseudo-random generators restart from their seed at the same point.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: While rst_ni is low, data_o is all zeros and valid_o is 0.
- R2: A sample taken at a rising clock edge with sample_valid_i high appears on data_o after that edge, and valid_o is 1 for that one cycle. In cycles without a strobe, valid_o is 0 and data_o holds its last value.
- R3: Mode 0000, and the unused codes 1101, 1110 and 1111, pass all 14 bits of adc_data_i to data_o unchanged.
- R4: word_len_i selects the word length: 00 gives 8 bits, 01 gives 10, 10 gives 12 and 11 gives 14. Pattern words are right-aligned in data_o, and every bit above the word length reads 0.
- R5: Mode 0001 (midscale) and mode 1011 (single high bit) both output a word with only its most significant bit set.
- R6: Mode 0010 outputs all ones, and mode 0011 outputs all zeros.
- R7: Mode 0100 alternates 1010… (MSB set) and then 0101… on successive samples. Mode 1001 outputs 1010… on every sample.
- R8: Mode 0111 alternates an all-ones word and then an all-zeros word on successive samples.
- R9: Mode 1000 alternates user_a_i and then user_b_i, each truncated to the word length.
- R10: Mode 1010 outputs a word whose lower half of bits is set: 0x0F, 0x01F, 0x03F or 0x007F for 8, 10, 12 or 14 bits.
- R11: Mode 1100 outputs the mixed-frequency word 0xA3, 0x263, 0xA33 or 0x2867 for 8, 10, 12 or 14 bits.
- R12: When a strobed sample's mode code differs from the previous strobed sample's mode, or on the first sample after reset, an alternating mode emits its first word.
- R13: Mode 0110 emits the state of a 9-bit LFSR. Mode 0101 emits the state of a 23-bit LFSR. Each word is the state's low bits, zero-extended and truncated to the word length. Each sample shows the current state, and the state then advances as {s[L-2:0], s[L-1]^s[T-1]}, with (L,T) = (9,5) and (23,18).
- R14: Both LFSR states return to all ones at a mode change (same condition as R12), so the first PN word after entering a PN mode comes from the all-ones state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Pattern select code |
| word_len_i | input | 2 | Word length code |
| user_a_i | input | 14 | First user word |
| user_b_i | input | 14 | Second user word |
| sample_valid_i | input | 1 | Sample strobe |
| adc_data_i | input | 14 | Live converter sample |
| data_o | output | 14 | Registered output word |
| valid_o | output | 1 | Output word strobe |

## Verification
Random streams mix every code, including the unused ones, with all four word lengths and irregular strobe gaps. This separates errors in the per-length word tables from errors in phase and LFSR sequencing. Directed 12-bit runs compare against literal words. They catch a model and a design that share a wrong formula. Mode flips between two alternating patterns, and between the two PN modes, tell apart a phase or seed that restarts correctly from one that only restarts after reset. Gaps without a strobe show whether the state advances per clock instead of per sample.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int unsigned MAX_W  = 14;
  localparam int unsigned MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    TP_OFF      = 4'd0,
    TP_MID      = 4'd1,
    TP_POS      = 4'd2,
    TP_NEG      = 4'd3,
    TP_CHECK    = 4'd4,
    TP_PN_LONG  = 4'd5,
    TP_PN_SHORT = 4'd6,
    TP_WTOGGLE  = 4'd7,
    TP_USER     = 4'd8,
    TP_ALTBITS  = 4'd9,
    TP_SYNC     = 4'd10,
    TP_ONEBIT   = 4'd11,
    TP_MIXED    = 4'd12
  } tp_mode_e;

  localparam logic [MODE_W-1:0] LAST_MODE = TP_MIXED;

  function automatic int unsigned wl_width(logic [1:0] wl);
    return 8 + 2 * int'(wl);
  endfunction

  function automatic logic [MAX_W-1:0] wl_mask(logic [1:0] wl);
    logic [MAX_W-1:0] m;
    for (int i = 0; i < MAX_W; i++) m[i] = (i < int'(wl_width(wl)));
    return m;
  endfunction

  function automatic logic [MAX_W-1:0] wl_msb(logic [1:0] wl);
    logic [MAX_W-1:0] m;
    for (int i = 0; i < MAX_W; i++) m[i] = (i == int'(wl_width(wl)) - 1);
    return m;
  endfunction

  // 1010... with the word MSB set
  function automatic logic [MAX_W-1:0] wl_alt(logic [1:0] wl);
    logic [MAX_W-1:0] m;
    for (int i = 0; i < MAX_W; i++)
      m[i] = (i < int'(wl_width(wl))) && (((int'(wl_width(wl)) - 1 - i) % 2) == 0);
    return m;
  endfunction

  function automatic logic [MAX_W-1:0] wl_sync(logic [1:0] wl);
    logic [MAX_W-1:0] m;
    for (int i = 0; i < MAX_W; i++) m[i] = (i < int'(wl_width(wl)) / 2);
    return m;
  endfunction
endpackage

// File: rtl/tpg_phase.sv
module tpg_phase
  import tpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              restart_o,
  output logic              phase_o
);
  logic [MODE_W-1:0] mode_q;
  logic              phase_q;

  assign restart_o = (mode_i != mode_q) || !phase_init_q;
  assign phase_o   = restart_o ? 1'b0 : phase_q;

  logic phase_init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= '0;
      phase_q      <= 1'b0;
      phase_init_q <= 1'b0;
    end else if (sample_i) begin
      mode_q       <= mode_i;
      phase_q      <= ~phase_o;
      phase_init_q <= 1'b1;
    end
  end

  // R12
  phase_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && restart_o) |=> phase_q);
endmodule

// File: rtl/tpg_prbs.sv
module tpg_prbs
  import tpg_pkg::*;
#(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             restart_i,
  input  logic             adv_i,
  output logic [MAX_W-1:0] word_o
);
  logic [LEN-1:0] st_q, cur, nxt;

  assign cur = restart_i ? {LEN{1'b1}} : st_q;
  assign nxt = {cur[LEN-2:0], cur[LEN-1] ^ cur[TAP-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       st_q <= {LEN{1'b1}};
    else if (sample_i) st_q <= adv_i ? nxt : cur;
  end

  generate
    if (LEN >= MAX_W) begin : g_trunc
      assign word_o = cur[MAX_W-1:0];
    end else begin : g_ext
      assign word_o = {{(MAX_W-LEN){1'b0}}, cur};
    end
  endgenerate

  // R13
  prbs_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
  // R14
  prbs_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && restart_i && !adv_i) |=> (st_q == {LEN{1'b1}}));
endmodule

// File: rtl/tpg_word_sel.sv
module tpg_word_sel
  import tpg_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        word_len_i,
  input  logic              phase_i,
  input  logic [MAX_W-1:0]  user_a_i,
  input  logic [MAX_W-1:0]  user_b_i,
  input  logic [MAX_W-1:0]  adc_data_i,
  input  logic [MAX_W-1:0]  pn_short_i,
  input  logic [MAX_W-1:0]  pn_long_i,
  output logic [MAX_W-1:0]  word_o
);
  logic [MAX_W-1:0] mask, alt, mixed, raw;
  tp_mode_e         sel;

  assign mask = wl_mask(word_len_i);
  assign alt  = wl_alt(word_len_i);
  assign sel  = (mode_i > LAST_MODE) ? TP_OFF : tp_mode_e'(mode_i);

  always_comb begin
    unique case (word_len_i)
      2'd0:    mixed = 14'h00A3;
      2'd1:    mixed = 14'h0263;
      2'd2:    mixed = 14'h0A33;
      default: mixed = 14'h2867;
    endcase
  end

  always_comb begin
    raw = '0;
    unique case (sel)
      TP_MID, TP_ONEBIT: raw = wl_msb(word_len_i);
      TP_POS:            raw = '1;
      TP_NEG:            raw = '0;
      TP_CHECK:          raw = phase_i ? ~alt : alt;
      TP_PN_LONG:        raw = pn_long_i;
      TP_PN_SHORT:       raw = pn_short_i;
      TP_WTOGGLE:        raw = phase_i ? '0 : '1;
      TP_USER:           raw = phase_i ? user_b_i : user_a_i;
      TP_ALTBITS:        raw = alt;
      TP_SYNC:           raw = wl_sync(word_len_i);
      TP_MIXED:          raw = mixed;
      default:           raw = adc_data_i;
    endcase
  end

  assign word_o = (sel == TP_OFF) ? adc_data_i : (raw & mask);
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        mode_i,
  input  logic [1:0]        word_len_i,
  input  logic [13:0]       user_a_i,
  input  logic [13:0]       user_b_i,
  input  logic              sample_valid_i,
  input  logic [13:0]       adc_data_i,
  output logic [13:0]       data_o,
  output logic              valid_o
);
  logic             restart, phase;
  logic [MAX_W-1:0] pn_short, pn_long, word;
  logic [MAX_W-1:0] data_q;
  logic             valid_q;

  tpg_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_valid_i),
    .mode_i    (mode_i),
    .restart_o (restart),
    .phase_o   (phase)
  );

  tpg_prbs #(.LEN(9), .TAP(5)) u_pn_short (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_valid_i),
    .restart_i (restart),
    .adv_i     (mode_i == TP_PN_SHORT),
    .word_o    (pn_short)
  );

  tpg_prbs #(.LEN(23), .TAP(18)) u_pn_long (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_valid_i),
    .restart_i (restart),
    .adv_i     (mode_i == TP_PN_LONG),
    .word_o    (pn_long)
  );

  tpg_word_sel u_sel (
    .mode_i     (mode_i),
    .word_len_i (word_len_i),
    .phase_i    (phase),
    .user_a_i   (user_a_i),
    .user_b_i   (user_b_i),
    .adc_data_i (adc_data_i),
    .pn_short_i (pn_short),
    .pn_long_i  (pn_long),
    .word_o     (word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= sample_valid_i;
      if (sample_valid_i) data_q <= word;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> valid_o);
  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> (!valid_o && $stable(data_o)));
  // R3
  pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && (mode_i == 4'd0 || mode_i > 4'd12)) |=> (data_o == $past(adc_data_i)));
  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && mode_i != 4'd0 && mode_i <= 4'd12)
      |=> ((data_o & ~wl_mask($past(word_len_i))) == '0));
  // R12
  check_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && restart && mode_i == 4'd4)
      |=> (data_o == wl_alt($past(word_len_i))));
endmodule

// File: tb/tb_adc_test_pattern_gen.sv
module tb_adc_test_pattern_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [1:0]  word_len_i = '0;
  logic [13:0] user_a_i = '0, user_b_i = '0, adc_data_i = '0;
  logic        sample_valid_i = 1'b0;
  logic [13:0] data_o;
  logic        valid_o;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 0;

  // model state
  logic [3:0]  m_prev = '0;
  bit          m_init = 0;
  bit          m_phase = 0;
  logic [8:0]  m_p9 = '1;
  logic [22:0] m_p23 = '1;
  logic [13:0] exp_data = '0;
  bit          exp_valid = 0;
  string       exp_tag = "R1";

  adc_test_pattern_gen dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic int w_of(logic [1:0] wl); return 8 + 2 * int'(wl); endfunction
  function automatic logic [13:0] mk(logic [1:0] wl); return 14'((32'd1 << w_of(wl)) - 1); endfunction
  function automatic logic [13:0] alt_of(logic [1:0] wl);
    case (wl) 2'd0: return 14'h00AA; 2'd1: return 14'h02AA; 2'd2: return 14'h0AAA; default: return 14'h2AAA; endcase
  endfunction
  function automatic logic [13:0] mix_of(logic [1:0] wl);
    case (wl) 2'd0: return 14'h00A3; 2'd1: return 14'h0263; 2'd2: return 14'h0A33; default: return 14'h2867; endcase
  endfunction
  function automatic string tag_of(logic [3:0] m);
    case (m)
      1, 11: return "R5";  2, 3: return "R6";  4, 9: return "R7";
      7: return "R8";  8: return "R9";  10: return "R10";  12: return "R11";
      5, 6: return "R13";  default: return "R3";
    endcase
  endfunction

  function automatic logic [13:0] model_word(logic [3:0] m, logic [1:0] wl, bit ph,
                                             logic [13:0] a, logic [13:0] b, logic [13:0] adc,
                                             logic [8:0] p9, logic [22:0] p23);
    logic [13:0] k = mk(wl);
    case (m)
      1, 11: return 14'(32'd1 << (w_of(wl) - 1));
      2: return k;
      3: return '0;
      4: return ph ? (~alt_of(wl) & k) : alt_of(wl);
      5: return p23[13:0] & k;
      6: return {5'd0, p9} & k;
      7: return ph ? '0 : k;
      8: return (ph ? b : a) & k;
      9: return alt_of(wl);
      10: return 14'((32'd1 << (w_of(wl) / 2)) - 1);
      12: return mix_of(wl);
      default: return adc;
    endcase
  endfunction

  task automatic check(string tag, logic [13:0] got, logic [13:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: data_o=%h expected %h", tag, got, exp);
    end
  endtask

  // called at a falling edge; result checked at the next falling edge
  task automatic cyc(logic [3:0] m, logic [1:0] wl, bit s, logic [13:0] adc);
    bit chg, ph;
    logic [8:0] p9c;
    logic [22:0] p23c;
    mode_i = m; word_len_i = wl; sample_valid_i = s; adc_data_i = adc;
    exp_valid = s;
    if (s) begin
      chg  = (m != m_prev) || !m_init;              // R12, R14
      ph   = chg ? 1'b0 : m_phase;
      p9c  = chg ? '1 : m_p9;
      p23c = chg ? '1 : m_p23;
      exp_data = model_word(m, wl, ph, user_a_i, user_b_i, adc, p9c, p23c);
      exp_tag  = chg && (m == 4 || m == 7 || m == 8) ? "R12" :
                 chg && (m == 5 || m == 6) ? "R14" : tag_of(m);
      m_phase = ~ph; m_prev = m; m_init = 1;
      m_p9  = (m == 6) ? {p9c[7:0], p9c[8] ^ p9c[4]} : p9c;
      m_p23 = (m == 5) ? {p23c[21:0], p23c[22] ^ p23c[17]} : p23c;
    end
    @(negedge clk_i);
    check(exp_tag, data_o, exp_data);
    n_chk++;
    if (valid_o !== exp_valid) begin
      n_fail++;
      $display("FAIL R2: valid_o=%0b expected %0b", valid_o, exp_valid);
    end
  endtask

  task automatic lit(string tag, logic [13:0] exp);
    check(tag, data_o, exp);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: data_o=%h expected completion", data_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1
    check("R1", data_o, 14'h0);
    n_chk++;
    if (valid_o !== 1'b0) begin n_fail++; $display("FAIL R1: valid_o=%0b expected 0", valid_o); end
    rst_ni = 1'b1;

    // directed 12-bit literals
    user_a_i = 14'h3C5A; user_b_i = 14'h1234;
    cyc(4'd4, 2'd2, 1, 14'h0); lit("R7", 14'h0AAA);
    cyc(4'd4, 2'd2, 1, 14'h0); lit("R7", 14'h0555);
    cyc(4'd4, 2'd2, 0, 14'h0); lit("R2", 14'h0555);
    cyc(4'd7, 2'd2, 1, 14'h0); lit("R12", 14'h0FFF);
    cyc(4'd4, 2'd2, 1, 14'h0); lit("R12", 14'h0AAA);
    cyc(4'd12, 2'd2, 1, 14'h0); lit("R11", 14'h0A33);
    cyc(4'd12, 2'd3, 1, 14'h0); lit("R11", 14'h2867);
    cyc(4'd10, 2'd2, 1, 14'h0); lit("R10", 14'h003F);
    cyc(4'd1, 2'd0, 1, 14'h0); lit("R5", 14'h0080);
    cyc(4'd11, 2'd3, 1, 14'h0); lit("R5", 14'h2000);
    cyc(4'd2, 2'd1, 1, 14'h0); lit("R4", 14'h03FF);
    cyc(4'd3, 2'd3, 1, 14'h0); lit("R6", 14'h0000);
    cyc(4'd8, 2'd0, 1, 14'h0); lit("R9", 14'h005A);
    cyc(4'd8, 2'd0, 1, 14'h0); lit("R9", 14'h0034);
    cyc(4'd15, 2'd0, 1, 14'h2BCD); lit("R3", 14'h2BCD);
    cyc(4'd6, 2'd3, 1, 14'h0); lit("R14", 14'h01FF);
    cyc(4'd6, 2'd3, 1, 14'h0); lit("R13", 14'h01FE);
    cyc(4'd6, 2'd3, 0, 14'h0);
    cyc(4'd6, 2'd3, 1, 14'h0); lit("R13", 14'h01FC);
    cyc(4'd5, 2'd3, 1, 14'h0); lit("R14", 14'h3FFF);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] m;
      if ($urandom_range(0, 3) == 0) m = 4'($urandom_range(0, 15));
      else m = (i % 50 < 25) ? m_prev : 4'($urandom_range(0, 12));
      if ($urandom_range(0, 20) == 0) begin
        user_a_i = 14'($urandom); user_b_i = 14'($urandom);
      end
      cyc(m, (i % 200 < 100) ? word_len_i : 2'($urandom), ($urandom_range(0, 3) != 0), 14'($urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule